// File: doc/BRIEF.md
# Host/Coprocessor Byte Mailbox

This block passes single bytes between a host CPU and a coprocessor, one holding byte in each direction. Each holding byte has a pending flag. The coprocessor can also raise an acknowledge flag. The host controls a reset line for the coprocessor, and the block emits a one-cycle reset pulse when the host lets go of that line.

The host reaches the block through a 24-bit address. Its registers sit in banks 0x00–0x3F and 0x80–0xBF, at offsets 0x3000–0x3FFF. Inside that window the offset is ANDed with 0xFF06, so many addresses alias onto the same three registers. The coprocessor sees the same state through a 6-bit offset. Both sides return read data in the same cycle as the read strobe. The side effects of a read or write take effect at the next clock edge.

Top module: `byte_mailbox`

## Requirements
- R1: A host access is decoded only when address bits [23:16] are in 0x00–0x3F or 0x80–0xBF and bits [15:12] equal 0x3. Any other host read returns 0, and any other host write changes nothing.
- R2: Inside the window the 16-bit offset is ANDed with 0xFF06 before the register is chosen. For example, 0x38F9 acts as 0x3800 and 0x3FFA acts as 0x3F02, which selects nothing. A folded offset that selects nothing reads 0.
- R3: A host read at folded offset 0x3800 returns the byte sent toward the host and clears the host-pending flag.
- R4: A host write at 0x3802 stores the byte toward the coprocessor and sets the coprocessor-pending flag. A host read at 0x3802 returns 0 and clears the acknowledge flag.
- R5: The status byte is bit0 = host-pending, bit2 = acknowledge, bit3 = coprocessor-pending, bit7 = NOT reset-held; all other bits are 0. The host reads it at 0x3804.
- R6: A host write at 0x3804 sets reset-held to (data != 0). A write that moves reset-held from 1 to 0 drives `cop_rst` high for exactly the one cycle after the write edge. No other write does this.
- R7: A coprocessor write at offset 0x00 stores the byte toward the host and sets host-pending. A coprocessor write at offset 0x10 sets acknowledge.
- R8: A coprocessor read at offset 0x10 returns the host's byte and clears coprocessor-pending. A read at offset 0x20 returns the status byte.
- R9: A coprocessor read at any other offset returns 0, and a coprocessor write at any other offset changes nothing.
- R10: After reset, status reads 0x80, both holding bytes are 0 and `cop_rst` is low.
- R11: When a set and a clear of the same flag occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | 24 | Host address (bank in [23:16]) |
| h_wdata | input | 8 | Host write data |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_rdata | output | 8 | Host read data, same cycle as h_rd |
| c_addr | input | 6 | Coprocessor register offset |
| c_wdata | input | 8 | Coprocessor write data |
| c_wr | input | 1 | Coprocessor write strobe |
| c_rd | input | 1 | Coprocessor read strobe |
| c_rdata | output | 8 | Coprocessor read data, same cycle as c_rd |
| cop_rst | output | 1 | One-cycle coprocessor reset pulse |

## Verification
Directed sequences come first and target specific corners:
- **Aliased and out-of-window addresses.** These show whether the bank limits and the 0xFF06 fold are decoded exactly as specified.
- **Set and clear in the same cycle.** These separate set-wins from clear-wins for each of the three flags.
- **Reset writes of 1→0, 0→0 and 1→1.** Only the first of these may pulse `cop_rst`.

A long seeded random run follows. It mixes strobes from both sides, including simultaneous ones, with biased addresses and data. A reference model in the bench predicts every read value and every `cop_rst` level, so ordering errors between the two sides show up as mismatches.

// File: rtl/byte_mailbox.sv
module byte_mailbox (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] h_addr,
  input  logic [7:0]  h_wdata,
  input  logic        h_wr,
  input  logic        h_rd,
  output logic [7:0]  h_rdata,
  input  logic [5:0]  c_addr,
  input  logic [7:0]  c_wdata,
  input  logic        c_wr,
  input  logic        c_rd,
  output logic [7:0]  c_rdata,
  output logic        cop_rst
);
  localparam logic [15:0] FOLD     = 16'hFF06;
  localparam logic [15:0] H_DATA   = 16'h3800;
  localparam logic [15:0] H_CMD    = 16'h3802;
  localparam logic [15:0] H_CTL    = 16'h3804;
  localparam logic [5:0]  C_TOHOST = 6'h00;
  localparam logic [5:0]  C_XCHG   = 6'h10;
  localparam logic [5:0]  C_STAT   = 6'h20;

  logic [7:0]  to_host, to_cop, status;
  logic        hpend, cpend, ack, held;
  logic [7:0]  bank;
  logic [15:0] fold;
  logic        h_win;
  logic        hs_data, hs_cmd, hs_ctl;
  logic        cs_tohost, cs_xchg, cs_stat;

  assign bank  = h_addr[23:16];
  assign fold  = h_addr[15:0] & FOLD;
  assign h_win = (bank <= 8'h3F || (bank >= 8'h80 && bank <= 8'hBF)) && h_addr[15:12] == 4'h3;

  assign hs_data = h_win && fold == H_DATA;
  assign hs_cmd  = h_win && fold == H_CMD;
  assign hs_ctl  = h_win && fold == H_CTL;

  assign cs_tohost = c_addr == C_TOHOST;
  assign cs_xchg   = c_addr == C_XCHG;
  assign cs_stat   = c_addr == C_STAT;

  assign status = {~held, 3'b000, cpend, ack, 1'b0, hpend};

  always_comb begin
    h_rdata = 8'h00;
    if (h_rd) begin
      if (hs_data)     h_rdata = to_host;
      else if (hs_ctl) h_rdata = status;
    end
  end

  always_comb begin
    c_rdata = 8'h00;
    if (c_rd) begin
      if (cs_xchg)      c_rdata = to_cop;
      else if (cs_stat) c_rdata = status;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      to_host <= 8'h00;
      to_cop  <= 8'h00;
      hpend   <= 1'b0;
      cpend   <= 1'b0;
      ack     <= 1'b0;
      held    <= 1'b0;
      cop_rst <= 1'b0;
    end else begin
      cop_rst <= 1'b0;
      if (h_rd && hs_data) hpend <= 1'b0;
      if (h_rd && hs_cmd)  ack   <= 1'b0;
      if (c_rd && cs_xchg) cpend <= 1'b0;
      if (c_wr && cs_tohost) begin
        to_host <= c_wdata;
        hpend   <= 1'b1;
      end
      if (c_wr && cs_xchg) ack <= 1'b1;
      if (h_wr && hs_cmd) begin
        to_cop <= h_wdata;
        cpend  <= 1'b1;
      end
      if (h_wr && hs_ctl) begin
        held    <= h_wdata != 8'h00;
        cop_rst <= held && h_wdata == 8'h00;
      end
    end
  end
endmodule

module byte_mailbox_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [23:0] h_addr,
  input logic        h_rd,
  input logic [7:0]  h_rdata,
  input logic [5:0]  c_addr,
  input logic        c_wr,
  input logic        c_rd,
  input logic [7:0]  c_rdata,
  input logic        cop_rst,
  input logic        hpend,
  input logic        ack
);
  logic [7:0] bk;
  logic       bank_ok, in_win;
  assign bk      = h_addr[23:16];
  assign bank_ok = bk <= 8'h3F || (bk >= 8'h80 && bk <= 8'hBF);
  assign in_win  = bank_ok && h_addr[15:12] == 4'h3;

  assert_outside_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && !in_win) |-> h_rdata == 8'h00);

  assert_status_spare_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && in_win && (h_addr[15:0] & 16'hFF06) == 16'h3804) |-> (h_rdata & 8'h72) == 8'h00);

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cop_rst |=> !cop_rst);

  assert_ack_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && c_addr == 6'h10) |=> ack);

  assert_unlisted_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && c_addr != 6'h10 && c_addr != 6'h20) |-> c_rdata == 8'h00);

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && c_addr == 6'h00) |=> hpend);

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && in_win && (h_addr[15:0] & 16'hFF06) == 16'h3800 && !(c_wr && c_addr == 6'h00)) |=> !hpend);
endmodule

bind byte_mailbox byte_mailbox_chk u_chk (
  .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_rd(h_rd), .h_rdata(h_rdata),
  .c_addr(c_addr), .c_wr(c_wr), .c_rd(c_rd), .c_rdata(c_rdata),
  .cop_rst(cop_rst), .hpend(hpend), .ack(ack)
);

// File: tb/byte_mailbox_bench.sv
module byte_mailbox_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] h_addr = '0;
  logic [7:0]  h_wdata = '0;
  logic        h_wr = 1'b0, h_rd = 1'b0;
  logic [7:0]  h_rdata;
  logic [5:0]  c_addr = '0;
  logic [7:0]  c_wdata = '0;
  logic        c_wr = 1'b0, c_rd = 1'b0;
  logic [7:0]  c_rdata;
  logic        cop_rst;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_th, m_tc;
  logic       m_hp, m_cp, m_ack, m_held;

  always #(CLK_P/2) clk = ~clk;

  byte_mailbox u_byte_mailbox (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wdata(h_wdata), .h_wr(h_wr),
    .h_rd(h_rd), .h_rdata(h_rdata), .c_addr(c_addr), .c_wdata(c_wdata),
    .c_wr(c_wr), .c_rd(c_rd), .c_rdata(c_rdata), .cop_rst(cop_rst)
  );

  // 0 none, 1 data, 2 cmd/ack, 3 control/status
  function automatic int hsel(logic [23:0] a);
    logic [7:0] b = a[23:16];
    logic [15:0] f = a[15:0] & 16'hFF06;
    if (!((b <= 8'h3F || (b >= 8'h80 && b <= 8'hBF)) && a[15:12] == 4'h3)) return 0;
    if (f == 16'h3800) return 1;
    if (f == 16'h3802) return 2;
    if (f == 16'h3804) return 3;
    return 0;
  endfunction

  function automatic logic [7:0] m_status();
    return {~m_held, 3'b000, m_cp, m_ack, 1'b0, m_hp};
  endfunction

  function automatic logic [7:0] exp_h(logic [23:0] a, logic rd);
    if (!rd) return 8'h00;
    case (hsel(a))
      1: return m_th;
      3: return m_status();
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_c(logic [5:0] a, logic rd);
    if (!rd) return 8'h00;
    if (a == 6'h10) return m_tc;
    if (a == 6'h20) return m_status();
    return 8'h00;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_th = 0; m_tc = 0; m_hp = 0; m_cp = 0; m_ack = 0; m_held = 0;
  endtask

  task automatic step(string tag, logic [23:0] ha, logic [7:0] hw, logic hwr, logic hrd,
                      logic [5:0] ca, logic [7:0] cw, logic cwr, logic crd);
    logic pulse;
    int s;
    @(negedge clk);
    h_addr = ha; h_wdata = hw; h_wr = hwr; h_rd = hrd;
    c_addr = ca; c_wdata = cw; c_wr = cwr; c_rd = crd;
    #1;
    check({tag, " host rdata"}, h_rdata, exp_h(ha, hrd));
    check({tag, " cop rdata"}, c_rdata, exp_c(ca, crd));
    s = hsel(ha);
    pulse = 1'b0;
    if (hrd && s == 1) m_hp = 0;
    if (hrd && s == 2) m_ack = 0;
    if (crd && ca == 6'h10) m_cp = 0;
    if (cwr && ca == 6'h00) begin m_th = cw; m_hp = 1; end
    if (cwr && ca == 6'h10) m_ack = 1;
    if (hwr && s == 2) begin m_tc = hw; m_cp = 1; end
    if (hwr && s == 3) begin pulse = m_held && hw == 0; m_held = hw != 0; end
    @(posedge clk); #1;
    check({tag, " cop_rst"}, {7'b0, cop_rst}, {7'b0, pulse});
  endtask

  task automatic idle(string tag);
    step(tag, 24'h0, 8'h0, 0, 0, 6'h3F, 8'h0, 0, 0);
  endtask

  function automatic logic [23:0] rand_haddr();
    logic [7:0] banks [8] = '{8'h00, 8'h3F, 8'h80, 8'hBF, 8'h40, 8'h7F, 8'hC0, 8'h12};
    logic [15:0] off;
    off = {4'h3, ($urandom % 4 != 0) ? 4'h8 : 4'($urandom), 8'($urandom)};
    if ($urandom % 4 == 0) off[7:3] = 5'h0;
    if ($urandom % 10 == 0) off[15:12] = 4'($urandom);
    return {banks[$urandom % 8], off};
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R10 cop_rst after reset", {7'b0, cop_rst}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    step("R10 status after reset", 24'h003804, 0, 0, 1, 6'h20, 0, 0, 1);
    step("R10 to_host after reset", 24'h003800, 0, 0, 1, 6'h10, 0, 0, 1);

    // R7 / R3 / R2: coprocessor sends, host reads through alias 0x38F9
    step("R7 cop write to host", 24'h0, 0, 0, 0, 6'h00, 8'hA5, 1, 0);
    step("R5 status hpend", 24'h803804, 0, 0, 1, 6'h3F, 0, 0, 0);
    step("R2 R3 alias data read", 24'h0038F9, 0, 0, 1, 6'h3F, 0, 0, 0);
    step("R3 hpend cleared", 24'h003804, 0, 0, 1, 6'h3F, 0, 0, 0);
    step("R2 fold to nothing", 24'h003FFA, 0, 0, 1, 6'h3F, 0, 0, 0);

    // R1: write outside the window ignored
    step("R1 bank 0x40 write", 24'h403802, 8'h77, 1, 0, 6'h3F, 0, 0, 0);
    step("R1 offset 0x2800 write", 24'h002802, 8'h77, 1, 0, 6'h3F, 0, 0, 0);
    step("R1 cpend unchanged", 24'h003804, 0, 0, 1, 6'h20, 0, 0, 1);

    // R4 / R8
    step("R4 host write cmd", 24'hBF3802, 8'h3C, 1, 0, 6'h3F, 0, 0, 0);
    step("R8 cop reads byte", 24'h0, 0, 0, 0, 6'h10, 0, 0, 1);
    step("R8 cpend cleared", 24'h0, 0, 0, 0, 6'h20, 0, 0, 1);
    step("R7 ack set", 24'h0, 0, 0, 0, 6'h10, 0, 1, 0);
    step("R4 ack read returns 0", 24'h003802, 0, 0, 1, 6'h20, 0, 0, 1);
    step("R4 ack cleared", 24'h003804, 0, 0, 1, 6'h3F, 0, 0, 0);

    // R9: unlisted coprocessor write ignored
    step("R9 unlisted write", 24'h0, 0, 0, 0, 6'h04, 8'hFF, 1, 0);
    step("R9 unlisted read", 24'h003804, 0, 0, 1, 6'h30, 0, 0, 1);

    // R6: reset edges
    step("R6 hold", 24'h003804, 8'h01, 1, 0, 6'h3F, 0, 0, 0);
    step("R6 held status", 24'h003804, 0, 0, 1, 6'h3F, 0, 0, 0);
    step("R6 1to1 no pulse", 24'h003804, 8'h80, 1, 0, 6'h3F, 0, 0, 0);
    step("R6 release pulse", 24'h003804, 8'h00, 1, 0, 6'h3F, 0, 0, 0);
    idle("R6 pulse one cycle");
    step("R6 0to0 no pulse", 24'h003804, 8'h00, 1, 0, 6'h3F, 0, 0, 0);

    // R11: set and clear together
    step("R11 hpend", 24'h003800, 0, 0, 1, 6'h00, 8'h11, 1, 0);
    step("R11 ack", 24'h003802, 0, 0, 1, 6'h10, 0, 1, 0);
    step("R11 cpend", 24'h003802, 8'h22, 1, 0, 6'h10, 0, 0, 1);
    step("R11 status", 24'h003804, 0, 0, 1, 6'h20, 0, 0, 1);

    for (int i = 0; i < 4000; i++) begin
      logic [23:0] ha = rand_haddr();
      logic [7:0]  hw = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
      logic [5:0]  ca = ($urandom % 4 == 0) ? 6'($urandom) : (($urandom % 2) ? 6'h10 : (($urandom % 2) ? 6'h00 : 6'h20));
      step("R1 R3 R4 R5 R6 R8 random", ha, hw, 1'($urandom % 3 == 0), 1'($urandom % 2),
           ca, 8'($urandom), 1'($urandom % 3 == 0), 1'($urandom % 2));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule